// File: doc/BRIEF.md
# Interrupt Coalescing Tick Controller

This block decides when a network controller should write its status block to host memory and raise an interrupt. It follows two streams of completion events: receive completions, and transmit completions (an advance of a send consumer index, meaning the DMA has moved the data, not that the frame has left on the wire). Each stream has three parts: a countdown timer clocked by an external 1 µs strobe, a running count of buffer descriptors since the last update, and a programmable descriptor threshold.

A timer reloads only when a status block update completes, whatever caused the update. An arriving event never reloads it. When a timer reaches zero it stays expired. It then requests an update only if its own class has an event pending. A send descriptor flagged "coalesce now" forces an update at once. The block holds at most one update request at a time. The request carries a reason mask, and triggers that arrive while the request waits are merged into that mask. The update engine answers with an acknowledge, which ends the request. A sticky error bit in a read-only status word records an acknowledge that arrived with no request open.

Top module: `coal_tick_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `upd_req` is 0, `upd_reason` is 0, `status` is 0 and both timers are at zero.
- R2: A timer decrements by one on each cycle with `us_tick` high while it is nonzero. It reloads from its tick setting only on a completed update (`upd_ack` with `upd_req` high), and an event does not reload it.
- R3: A timer at zero with a nonzero tick setting raises a request one cycle later, but only while its class has an event pending. The reason bits are: bit 0 for the receive timer and bit 2 for the transmit timer.
- R4: A tick setting of 0 disables that class's timer path, so pending events of that class never raise reason bit 0 or 2.
- R5: Each class adds `*_bd_cnt` into a saturating descriptor count on each event. With a nonzero threshold, a count at or above the threshold raises a request one cycle later with reason bit 1 (receive) or bit 3 (transmit). A threshold of 0 disables this path.
- R6: A transmit event with `tx_coal_now` high raises `upd_req` at the next edge with reason bit 4, whatever the timers hold.
- R7: A completed update clears the pending flags and descriptor counts of both classes and reloads both timers. An event in the acknowledge cycle is recorded after the clear.
- R8: Only one request is outstanding at a time. Once raised, `upd_req` stays high until acknowledged, and the reason bits only accumulate. In the acknowledge cycle, `upd_req` next holds only a same-cycle forced trigger.
- R9: An `upd_ack` while `upd_req` is low sets `status[2]`, which stays set until reset. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle 1 µs strobe |
| rx_evt | input | 1 | Receive completion pulse |
| rx_bd_cnt | input | CNT_W | Descriptors in this receive completion |
| tx_evt | input | 1 | Send consumer index advance pulse |
| tx_bd_cnt | input | CNT_W | Descriptors in this send completion |
| tx_coal_now | input | 1 | Coalesce-now flag of the send completion |
| rx_tick_cfg | input | TICK_W | Receive timer reload value, 0 disables |
| tx_tick_cfg | input | TICK_W | Transmit timer reload value, 0 disables |
| rx_max_bd | input | CNT_W | Receive descriptor threshold, 0 disables |
| tx_max_bd | input | CNT_W | Transmit descriptor threshold, 0 disables |
| upd_ack | input | 1 | Status block update done |
| upd_req | output | 1 | Update request outstanding |
| upd_reason | output | 5 | Accumulated trigger mask |
| status | output | 32 | Read-only status word, error at bit 2 |

## Verification
Every cycle, assertions check that timers hold between strobes, that a completed update clears each class, and that an open request neither drops nor loses reason bits. They also check that a forced trigger is taken at the next edge and that the error bit never clears. Whether a timer fires at the right strobe count, and whether disabled paths stay quiet, depends on event and strobe timing. Only the bench's scenarios show these, by comparing the ports with a cycle model built from the requirements.

// File: rtl/coal_pkg.sv
// Shared constants for the coalescing controller: reason mask layout and
// status word geometry. Assumes reason bits are a plain OR-able mask.
package coal_pkg;
    localparam int REASON_W   = 5;
    localparam int RSN_RX_TMR = 0;
    localparam int RSN_RX_CNT = 1;
    localparam int RSN_TX_TMR = 2;
    localparam int RSN_TX_CNT = 3;
    localparam int RSN_FORCE  = 4;
    localparam int STAT_W     = 32;
    localparam int STAT_ERR   = 2;
endpackage

// File: rtl/coal_class_trk.sv
// Per-class tracker: countdown timer, saturating descriptor count and
// pending flag for one event stream. Assumes upd_done is asserted only for a
// completed update (ack while a request is open). Outputs are registered-state
// decodes, so a trigger reaches the request stage one edge after the state.
module coal_class_trk #(
    parameter int TICK_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              evt,
    input  logic [CNT_W-1:0]  bd_cnt,
    input  logic [TICK_W-1:0] tick_cfg,
    input  logic [CNT_W-1:0]  max_bd,
    input  logic              upd_done,
    output logic              timer_trig,
    output logic              count_trig
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [TICK_W-1:0] timer_q;
    logic [CNT_W-1:0]  count_q;
    logic              pend_q;
    logic [CNT_W:0]    sum;

    // Saturating sum of the running count and the new descriptors.
    always_comb begin
        sum = {1'b0, count_q} + {1'b0, bd_cnt};
    end

    // Timer: reload on completed update, else count down on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            timer_q <= '0;
        else if (upd_done)
            timer_q <= tick_cfg;
        else if (tick && timer_q != '0)
            timer_q <= timer_q - 1'b1;
    end

    // Pending flag and descriptor count: cleared by update, then fed by events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            pend_q  <= 1'b0;
        end else if (upd_done) begin
            count_q <= evt ? bd_cnt : '0;
            pend_q  <= evt;
        end else if (evt) begin
            count_q <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
            pend_q  <= 1'b1;
        end
    end

    // Trigger decode from state and configuration.
    always_comb begin
        timer_trig = (tick_cfg != '0) && (timer_q == '0) && pend_q;
        count_trig = (max_bd != '0) && (count_q >= max_bd);
    end

    p_timer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !upd_done) |=> $stable(timer_q));
    p_clear_on_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !evt) |=> (count_q == '0 && !pend_q));
    p_evt_sets_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend_q);
endmodule

// File: rtl/coal_req_arb.sv
// Request stage: keeps one outstanding update request and merges new
// triggers into its reason mask. Flags a stray acknowledge as a sticky error.
// Assumes trig bits are level decodes that may repeat every cycle.
module coal_req_arb
    import coal_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REASON_W-1:0] trig,
    input  logic                ack,
    output logic                upd_req,
    output logic [REASON_W-1:0] upd_reason,
    output logic                err
);
    logic done;

    // A completed update is an acknowledge against an open request.
    always_comb begin
        done = ack && upd_req;
    end

    // Request register: open on any trigger, merge while waiting, close on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_req    <= 1'b0;
            upd_reason <= '0;
        end else if (done) begin
            upd_req    <= trig[RSN_FORCE];
            upd_reason <= trig & (REASON_W'(1) << RSN_FORCE);
        end else if (upd_req) begin
            upd_reason <= upd_reason | trig;
        end else begin
            upd_req    <= |trig;
            upd_reason <= trig;
        end
    end

    // Sticky error on acknowledge with nothing outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (ack && !upd_req)
            err <= 1'b1;
    end

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !ack) |=> upd_req);
    p_reason_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !ack) |=> ((upd_reason & $past(upd_reason)) == $past(upd_reason)));
    p_req_has_reason_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |-> (upd_reason != '0));
    p_force_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig[RSN_FORCE] |=> (upd_req && upd_reason[RSN_FORCE]));
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/coal_tick_ctrl.sv
// Top of the coalescing controller: two class trackers feed the request
// stage. A transmit completion with the coalesce-now flag is a direct trigger.
// Assumes event pulses and us_tick are single-cycle and synchronous to clk.
module coal_tick_ctrl
    import coal_pkg::*;
#(
    parameter int TICK_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                us_tick,
    input  logic                rx_evt,
    input  logic [CNT_W-1:0]    rx_bd_cnt,
    input  logic                tx_evt,
    input  logic [CNT_W-1:0]    tx_bd_cnt,
    input  logic                tx_coal_now,
    input  logic [TICK_W-1:0]   rx_tick_cfg,
    input  logic [TICK_W-1:0]   tx_tick_cfg,
    input  logic [CNT_W-1:0]    rx_max_bd,
    input  logic [CNT_W-1:0]    tx_max_bd,
    input  logic                upd_ack,
    output logic                upd_req,
    output logic [REASON_W-1:0] upd_reason,
    output logic [STAT_W-1:0]   status
);
    localparam int NCLS = 2;

    logic [NCLS-1:0]   cls_evt;
    logic [CNT_W-1:0]  cls_bd   [NCLS];
    logic [TICK_W-1:0] cls_tick [NCLS];
    logic [CNT_W-1:0]  cls_max  [NCLS];
    logic [NCLS-1:0]   tmr_trig;
    logic [NCLS-1:0]   cnt_trig;
    logic [REASON_W-1:0] trig;
    logic              upd_done;
    logic              err;

    // Gather per-class inputs into arrays indexed 0 = receive, 1 = transmit.
    always_comb begin
        cls_evt     = {tx_evt, rx_evt};
        cls_bd[0]   = rx_bd_cnt;
        cls_bd[1]   = tx_bd_cnt;
        cls_tick[0] = rx_tick_cfg;
        cls_tick[1] = tx_tick_cfg;
        cls_max[0]  = rx_max_bd;
        cls_max[1]  = tx_max_bd;
        upd_done    = upd_ack && upd_req;
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        coal_class_trk #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (us_tick),
            .evt        (cls_evt[c]),
            .bd_cnt     (cls_bd[c]),
            .tick_cfg   (cls_tick[c]),
            .max_bd     (cls_max[c]),
            .upd_done   (upd_done),
            .timer_trig (tmr_trig[c]),
            .count_trig (cnt_trig[c])
        );
    end

    // Assemble the trigger mask in reason-bit order.
    always_comb begin
        trig             = '0;
        trig[RSN_RX_TMR] = tmr_trig[0];
        trig[RSN_RX_CNT] = cnt_trig[0];
        trig[RSN_TX_TMR] = tmr_trig[1];
        trig[RSN_TX_CNT] = cnt_trig[1];
        trig[RSN_FORCE]  = tx_evt && tx_coal_now;
    end

    coal_req_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .ack        (upd_ack),
        .upd_req    (upd_req),
        .upd_reason (upd_reason),
        .err        (err)
    );

    // Read-only status word: only the error bit is live.
    always_comb begin
        status           = '0;
        status[STAT_ERR] = err;
    end

    p_status_zero_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && !upd_req));
endmodule

// File: tb/tb_coal_tick_ctrl.sv
module tb_coal_tick_ctrl;
    localparam int TW = 10;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 0, rx_evt = 0, tx_evt = 0, tx_coal_now = 0, upd_ack = 0;
    logic [CW-1:0] rx_bd_cnt = '0, tx_bd_cnt = '0, rx_max_bd = '0, tx_max_bd = '0;
    logic [TW-1:0] rx_tick_cfg = '0, tx_tick_cfg = '0;
    logic upd_req;
    logic [4:0] upd_reason;
    logic [31:0] status;

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R1";

    // reference model state
    int m_tmr[2], m_cnt[2];
    bit m_pend[2];
    bit m_req, m_err;
    logic [4:0] m_rsn;

    always #5 clk = ~clk;

    coal_tick_ctrl #(.TICK_W(TW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .rx_evt(rx_evt), .rx_bd_cnt(rx_bd_cnt),
        .tx_evt(tx_evt), .tx_bd_cnt(tx_bd_cnt), .tx_coal_now(tx_coal_now),
        .rx_tick_cfg(rx_tick_cfg), .tx_tick_cfg(tx_tick_cfg),
        .rx_max_bd(rx_max_bd), .tx_max_bd(tx_max_bd),
        .upd_ack(upd_ack), .upd_req(upd_req), .upd_reason(upd_reason),
        .status(status));

    function automatic int sat_add(int a, int b);
        return (a + b > 255) ? 255 : a + b;
    endfunction

    // Cycle model built from R2..R9.
    always @(posedge clk) begin
        int tcfg[2], mx[2], bd[2];
        bit ev[2], done;
        logic [4:0] tr;
        tcfg[0] = rx_tick_cfg; tcfg[1] = tx_tick_cfg;
        mx[0] = rx_max_bd; mx[1] = tx_max_bd;
        bd[0] = rx_bd_cnt; bd[1] = tx_bd_cnt;
        ev[0] = rx_evt; ev[1] = tx_evt;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin m_tmr[c] = 0; m_cnt[c] = 0; m_pend[c] = 0; end
            m_req = 0; m_rsn = '0; m_err = 0;
        end else begin
            done = upd_ack && m_req;
            tr = '0;
            for (int c = 0; c < 2; c++) begin
                tr[2*c]   = (tcfg[c] != 0) && (m_tmr[c] == 0) && m_pend[c];
                tr[2*c+1] = (mx[c] != 0) && (m_cnt[c] >= mx[c]);
            end
            tr[4] = tx_evt && tx_coal_now;
            if (upd_ack && !m_req) m_err = 1;
            if (done) begin m_req = tr[4]; m_rsn = {tr[4], 4'b0}; end
            else if (m_req) m_rsn = m_rsn | tr;
            else begin m_req = |tr; m_rsn = tr; end
            for (int c = 0; c < 2; c++) begin
                if (done) begin
                    m_tmr[c] = tcfg[c]; m_cnt[c] = ev[c] ? bd[c] : 0; m_pend[c] = ev[c];
                end else begin
                    if (us_tick && m_tmr[c] != 0) m_tmr[c]--;
                    if (ev[c]) begin m_cnt[c] = sat_add(m_cnt[c], bd[c]); m_pend[c] = 1; end
                end
            end
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            report();
        end
    end

    task automatic compare();
        checks++;
        if (upd_req !== m_req || upd_reason !== m_rsn || status !== {29'b0, m_err, 2'b0}) begin
            fails++;
            $display("FAIL %s t=%0t: actual req=%b rsn=%b stat=%h expected req=%b rsn=%b stat=%h",
                     tag, $time, upd_req, upd_reason, status, m_req, m_rsn, {29'b0, m_err, 2'b0});
        end
    endtask

    // One clock: apply current inputs, check after the edge, clear pulses.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
        us_tick = 0; rx_evt = 0; tx_evt = 0; tx_coal_now = 0; upd_ack = 0;
    endtask

    task automatic run(int n, bit ticks);
        for (int i = 0; i < n; i++) begin us_tick = ticks; cyc(); end
    endtask

    task automatic ack_now();
        upd_ack = 1; cyc();
    endtask

    initial begin
        void'($urandom(1234));
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1;
        tag = "R1"; compare();

        // R6: forced update from a flagged send completion, then reload timers.
        tag = "R6";
        rx_tick_cfg = 3; tx_tick_cfg = 0; rx_max_bd = 0; tx_max_bd = 0;
        tx_evt = 1; tx_coal_now = 1; tx_bd_cnt = 1; cyc();
        if (upd_req !== 1'b1 || upd_reason[4] !== 1'b1) begin
            fails++; $display("FAIL R6: actual req=%b rsn=%b expected req=1 rsn[4]=1", upd_req, upd_reason);
        end
        checks++;
        ack_now();

        // R2/R3: timer reloaded to 3; event must not reload; fires after 3 strobes.
        tag = "R2";
        rx_evt = 1; rx_bd_cnt = 1; cyc();
        run(2, 1); run(3, 0);
        if (upd_req !== 1'b0) begin fails++; $display("FAIL R2: actual req=%b expected 0", upd_req); end
        checks++;
        rx_evt = 1; cyc();
        tag = "R3";
        run(1, 1); run(2, 0);
        if (upd_req !== 1'b1 || upd_reason[0] !== 1'b1) begin
            fails++; $display("FAIL R3: actual req=%b rsn=%b expected req=1 rsn[0]=1", upd_req, upd_reason);
        end
        checks++;
        ack_now();

        // R4: receive timer disabled; R5: threshold path then fires.
        tag = "R4";
        rx_tick_cfg = 0; rx_max_bd = 3;
        rx_evt = 1; rx_bd_cnt = 1; cyc();
        run(10, 1);
        if (upd_req !== 1'b0) begin fails++; $display("FAIL R4: actual req=%b expected 0", upd_req); end
        checks++;
        tag = "R5";
        rx_evt = 1; cyc(); rx_evt = 1; cyc(); cyc();
        if (upd_req !== 1'b1 || upd_reason[1] !== 1'b1) begin
            fails++; $display("FAIL R5: actual req=%b rsn=%b expected req=1 rsn[1]=1", upd_req, upd_reason);
        end
        checks++;

        // R7: ack clears both classes; nothing fires until new events.
        tag = "R7";
        tx_tick_cfg = 2; tx_evt = 1; tx_bd_cnt = 2; cyc();
        ack_now();
        run(8, 1);
        if (upd_req !== 1'b0) begin fails++; $display("FAIL R7: actual req=%b expected 0", upd_req); end
        checks++;

        // R8: constrained random with merged triggers.
        tag = "R8";
        for (int seg = 0; seg < 8; seg++) begin
            rx_tick_cfg = TW'($urandom_range(0, 6));
            tx_tick_cfg = TW'($urandom_range(0, 6));
            rx_max_bd = CW'($urandom_range(0, 8));
            tx_max_bd = CW'($urandom_range(0, 8));
            for (int i = 0; i < 400; i++) begin
                us_tick = ($urandom_range(0, 2) == 0);
                rx_evt = ($urandom_range(0, 4) == 0);
                rx_bd_cnt = CW'($urandom_range(0, (seg == 7) ? 255 : 4));
                tx_evt = ($urandom_range(0, 4) == 0);
                tx_bd_cnt = CW'($urandom_range(0, (seg == 7) ? 255 : 4));
                tx_coal_now = tx_evt && ($urandom_range(0, 15) == 0);
                upd_ack = upd_req && ($urandom_range(0, 3) == 0);
                cyc();
            end
        end
        while (upd_req) ack_now();

        // R9: stray acknowledge sets sticky error at status bit 2.
        tag = "R9";
        run(3, 0);
        ack_now();
        if (status !== 32'h4) begin fails++; $display("FAIL R9: actual status=%h expected 00000004", status); end
        checks++;
        tx_evt = 1; tx_coal_now = 1; cyc(); ack_now();
        run(3, 0);
        if (status !== 32'h4) begin fails++; $display("FAIL R9: actual status=%h expected 00000004", status); end
        checks++;
        rst_n = 0; cyc(); rst_n = 1;
        tag = "R1"; compare();
        report();
    end
endmodule